// File: doc/BRIEF.md
# Privilege-Aware Bus Address Decoder

This block sits between a 32-bit CPU bus and the memories and peripheral cores of a small secure device. Each cycle it looks at the bus address and the read/write strobes. It raises one select line for the memory or core addressed, returns that target's read data, and passes on the write strobe and write data when the access is allowed. The two top address bits pick the region. In the memory-mapped region, the top address byte picks one of seven peripheral cores.

The decoder also holds the privilege state. After reset the device runs in firmware mode. Any write to the mode register moves it for good into application mode, and only reset brings it back. In application mode, some targets vanish from the bus: the firmware-only RAM, the secret-key core, and the device-identity and memory-seed registers in the system control core. Each of the eight secret-key words can be read once per reset. A repeat read of a word sees zero. Any access the decoder refuses returns zero, forwards nothing and raises `denied` in the same cycle.

Top module: `mmio_gatekeeper`

## Requirements
- R1: A bus address in 0x0000_0000..0x0000_17FF raises `sel_rom`. An address in 0x4000_0000..0x4001_FFFF raises `sel_ram`. Any other address whose bits [31:30] are 00 or 01 is refused.
- R2: When bits [31:30] are 11, address bits [31:24] pick a core, and `sel_core` bit n follows the order 0:0xC0 entropy, 1:0xC1 timer, 2:0xC2 secret key, 3:0xC3 UART, 4:0xC4 touch, 5:0xD0 firmware RAM, 6:0xFF system control. At most one select is high in any cycle.
- R3: An access to region 10, or to an unassigned core prefix, is refused. A refused access raises no select, returns `rdata` = 0, and raises `denied` in the same cycle.
- R4: A granted read returns the addressed target's read-data input on `rdata` in the same cycle. When no read is made, `rdata` is 0.
- R5: The mode register is at 0xFF00_0100. A read of it returns 0 in firmware mode and 0xFFFFFFFF in application mode, and raises no core select. A write of any value in firmware mode sets `app_mode` from the next cycle.
- R6: `app_mode` is 0 after reset and never falls again until the next reset. In application mode, a write to the mode register is refused.
- R7: In application mode, every access to core prefix 0xD0 or 0xC2 is refused.
- R8: In application mode, the system-control offsets 0x200 and 0x204 (device identity) and 0x300 and 0x304 (memory seeds) are refused. Other system-control offsets still pass.
- R9: Secret-key word k sits at core offset 4·k, for k = 0..7. The first read of word k after reset is granted. Every later read of word k is refused, starting from the next cycle. Other words are not affected.
- R10: A write to the secret-key core is refused. A read at a secret-key offset of 0x20 or above is refused.
- R11: `out_wr` and `out_rd` are high only for granted writes and granted reads. `out_wdata` equals `bus_wdata` during a granted write and is 0 at all other times.
- R12: Reset makes every secret-key word readable once again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Bus byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| rom_rdata | input | 32 | ROM read data |
| ram_rdata | input | 32 | RAM read data |
| core_rdata | input | 224 | Core read data, core n in bits [32n+31:32n] |
| sel_rom | output | 1 | ROM select |
| sel_ram | output | 1 | RAM select |
| sel_core | output | 7 | Core selects, one bit per core |
| out_rd | output | 1 | Granted read strobe |
| out_wr | output | 1 | Granted write strobe |
| out_wdata | output | 32 | Forwarded write data |
| rdata | output | 32 | Read data to the CPU |
| denied | output | 1 | Refused access in this cycle |
| app_mode | output | 1 | 1 in application mode |

## Verification
Two state changes share a cycle with the access that causes them. In that cycle the access must still be judged by the old state.

The first case is the switch to application mode. A mode write is followed at once, with no gap, by a firmware-RAM read. The bench expects `app_mode` to be 0 during the write and the read to be refused one cycle later.

The second case is the once-only key read. The same key word is read in two back-to-back cycles. The bench expects the first read to return the core's data with `denied` low, and the second to return 0 with `denied` high.

// File: rtl/gk_pkg.sv
package gk_pkg;
   typedef enum logic [1:0] {
      RGN_ROM  = 2'b00,
      RGN_RAM  = 2'b01,
      RGN_RSV  = 2'b10,
      RGN_MMIO = 2'b11
   } region_e;

   localparam int NUM_CORES  = 7;
   localparam int CORE_RNG   = 0;
   localparam int CORE_TMR   = 1;
   localparam int CORE_KEY   = 2;
   localparam int CORE_UART  = 3;
   localparam int CORE_TOUCH = 4;
   localparam int CORE_FWRAM = 5;
   localparam int CORE_SYS   = 6;

   localparam logic [23:0] OFS_MODE   = 24'h000100;
   localparam logic [23:0] OFS_ID_LO  = 24'h000200;
   localparam logic [23:0] OFS_ID_HI  = 24'h000204;
   localparam logic [23:0] OFS_SEED_A = 24'h000300;
   localparam logic [23:0] OFS_SEED_B = 24'h000304;

   function automatic logic [7:0] core_prefix(input int idx);
      case (idx)
         CORE_RNG:   return 8'hC0;
         CORE_TMR:   return 8'hC1;
         CORE_KEY:   return 8'hC2;
         CORE_UART:  return 8'hC3;
         CORE_TOUCH: return 8'hC4;
         CORE_FWRAM: return 8'hD0;
         default:    return 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/gk_addr_decode.sv
module gk_addr_decode
   import gk_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int ROM_BYTES = 32'h1800,
   parameter int RAM_BYTES = 32'h20000,
   parameter int KEY_WORDS = 8,
   parameter int N_CORES   = NUM_CORES,
   localparam int KIDX_W   = $clog2(KEY_WORDS)
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic               rom_hit,
   output logic               ram_hit,
   output logic [N_CORES-1:0] core_hit,
   output logic               mode_hit,
   output logic               guarded_hit,
   output logic               key_in_range,
   output logic [KIDX_W-1:0]  key_idx
);
   localparam logic [29:0] ROM_LIM = 30'(ROM_BYTES);
   localparam logic [29:0] RAM_LIM = 30'(RAM_BYTES);
   localparam logic [23:0] KEY_LIM = 24'(KEY_WORDS * 4);

   if (ADDR_W != 32) begin : g_bad_addr
      $error("gk_addr_decode: ADDR_W must be 32");
   end
   if ((1 << KIDX_W) != KEY_WORDS) begin : g_bad_key
      $error("gk_addr_decode: KEY_WORDS must be a power of two");
   end

   region_e            rgn;
   logic [23:0]        ofs;

   assign rgn = region_e'(addr[31:30]);
   assign ofs = addr[23:0];

   assign rom_hit = (rgn == RGN_ROM) && (addr[29:0] < ROM_LIM);
   assign ram_hit = (rgn == RGN_RAM) && (addr[29:0] < RAM_LIM);

   for (genvar c = 0; c < N_CORES; c++) begin : g_core
      assign core_hit[c] = (rgn == RGN_MMIO) && (addr[31:24] == core_prefix(c));
   end

   assign mode_hit     = (ofs == OFS_MODE);
   assign guarded_hit  = (ofs == OFS_ID_LO) || (ofs == OFS_ID_HI) ||
                         (ofs == OFS_SEED_A) || (ofs == OFS_SEED_B);
   assign key_in_range = (ofs < KEY_LIM);
   assign key_idx      = addr[KIDX_W+1:2];
endmodule

// File: rtl/gk_mode_latch.sv
module gk_mode_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   output logic app_mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       app_mode <= 1'b0;
      else if (set_req) app_mode <= 1'b1;
   end
endmodule

// File: rtl/gk_once_gate.sv
module gk_once_gate #(
   parameter int KEY_WORDS = 8,
   localparam int KIDX_W   = $clog2(KEY_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 consume,
   input  logic [KIDX_W-1:0]    idx,
   output logic [KEY_WORDS-1:0] used
);
   for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 used[w] <= 1'b0;
         else if (consume && (idx == KIDX_W'(w)))    used[w] <= 1'b1;
      end
   end
endmodule

// File: rtl/gk_rdata_mux.sv
module gk_rdata_mux #(
   parameter int N_CORES = 7,
   parameter int DATA_W  = 32
) (
   input  logic                      rom_en,
   input  logic                      ram_en,
   input  logic [N_CORES-1:0]        core_en,
   input  logic                      int_en,
   input  logic [DATA_W-1:0]         rom_d,
   input  logic [DATA_W-1:0]         ram_d,
   input  logic [N_CORES*DATA_W-1:0] core_d,
   input  logic [DATA_W-1:0]         int_d,
   output logic [DATA_W-1:0]         q
);
   logic [DATA_W-1:0] part [N_CORES+1];

   assign part[0] = ({DATA_W{rom_en}} & rom_d) |
                    ({DATA_W{ram_en}} & ram_d) |
                    ({DATA_W{int_en}} & int_d);

   for (genvar c = 0; c < N_CORES; c++) begin : g_or
      assign part[c+1] = part[c] |
                         ({DATA_W{core_en[c]}} & core_d[c*DATA_W +: DATA_W]);
   end

   assign q = part[N_CORES];
endmodule

// File: rtl/mmio_gatekeeper.sv
module mmio_gatekeeper
   import gk_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int ROM_BYTES = 32'h1800,
   parameter int RAM_BYTES = 32'h20000,
   parameter int KEY_WORDS = 8,
   localparam int N_CORES  = NUM_CORES,
   localparam int KIDX_W   = $clog2(KEY_WORDS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic                      bus_rd,
   input  logic                      bus_wr,
   input  logic [DATA_W-1:0]         bus_wdata,
   input  logic [DATA_W-1:0]         rom_rdata,
   input  logic [DATA_W-1:0]         ram_rdata,
   input  logic [N_CORES*DATA_W-1:0] core_rdata,
   output logic                      sel_rom,
   output logic                      sel_ram,
   output logic [N_CORES-1:0]        sel_core,
   output logic                      out_rd,
   output logic                      out_wr,
   output logic [DATA_W-1:0]         out_wdata,
   output logic [DATA_W-1:0]         rdata,
   output logic                      denied,
   output logic                      app_mode
);
   if (DATA_W < 8) begin : g_bad_data
      $error("mmio_gatekeeper: DATA_W too small");
   end

   logic               rom_hit, ram_hit, mode_hit, guarded_hit, key_in_range;
   logic [N_CORES-1:0] core_hit, core_ok;
   logic [KIDX_W-1:0]  key_idx;
   logic [KEY_WORDS-1:0] key_used;
   logic               access, ext_ok, mode_ok, key_ok, mode_set, key_take;

   gk_addr_decode #(
      .ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES),
      .KEY_WORDS(KEY_WORDS), .N_CORES(N_CORES)
   ) u_dec (
      .addr(bus_addr), .rom_hit(rom_hit), .ram_hit(ram_hit),
      .core_hit(core_hit), .mode_hit(mode_hit), .guarded_hit(guarded_hit),
      .key_in_range(key_in_range), .key_idx(key_idx)
   );

   assign access  = bus_rd | bus_wr;
   assign key_ok  = !app_mode && key_in_range && bus_rd && !bus_wr &&
                    !key_used[key_idx];
   assign mode_ok = core_hit[CORE_SYS] && mode_hit && !(bus_wr && app_mode);

   for (genvar c = 0; c < N_CORES; c++) begin : g_rule
      if (c == CORE_KEY) begin : g_key
         assign core_ok[c] = key_ok;
      end else if (c == CORE_FWRAM) begin : g_fw
         assign core_ok[c] = !app_mode;
      end else if (c == CORE_SYS) begin : g_sys
         assign core_ok[c] = !mode_hit && !(guarded_hit && app_mode);
      end else begin : g_open
         assign core_ok[c] = 1'b1;
      end
   end

   assign ext_ok    = rom_hit | ram_hit | (|(core_hit & core_ok));
   assign denied    = access && !ext_ok && !mode_ok;

   assign sel_rom   = access & rom_hit;
   assign sel_ram   = access & ram_hit;
   assign sel_core  = {N_CORES{access}} & core_hit & core_ok;
   assign out_rd    = bus_rd & ext_ok;
   assign out_wr    = bus_wr & ext_ok;
   assign out_wdata = out_wr ? bus_wdata : '0;

   assign mode_set  = bus_wr && mode_ok && !app_mode;
   assign key_take  = core_hit[CORE_KEY] && key_ok;

   gk_mode_latch u_mode (
      .clk(clk), .rst_n(rst_n), .set_req(mode_set), .app_mode(app_mode)
   );

   gk_once_gate #(.KEY_WORDS(KEY_WORDS)) u_gate (
      .clk(clk), .rst_n(rst_n), .consume(key_take), .idx(key_idx), .used(key_used)
   );

   gk_rdata_mux #(.N_CORES(N_CORES), .DATA_W(DATA_W)) u_mux (
      .rom_en(bus_rd & sel_rom), .ram_en(bus_rd & sel_ram),
      .core_en({N_CORES{bus_rd}} & sel_core), .int_en(bus_rd & mode_ok),
      .rom_d(rom_rdata), .ram_d(ram_rdata), .core_d(core_rdata),
      .int_d({DATA_W{app_mode}}), .q(rdata)
   );
endmodule

// File: rtl/gatekeeper_chk.sv
module gatekeeper_chk #(
   parameter int N_CORES = 7,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [31:0]        bus_addr,
   input logic               bus_rd,
   input logic               bus_wr,
   input logic               sel_rom,
   input logic               sel_ram,
   input logic [N_CORES-1:0] sel_core,
   input logic               out_wr,
   input logic [DATA_W-1:0]  rdata,
   input logic               denied,
   input logic               app_mode
);
   // R2
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_rom, sel_ram, sel_core}));

   // R3
   denied_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      denied |-> (!sel_rom && !sel_ram && sel_core == '0 && rdata == '0));

   // R6
   mode_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_mode |=> app_mode);

   // R5
   mode_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(app_mode) |-> $past(bus_wr));

   // R7
   fwram_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (app_mode && (bus_rd || bus_wr) && bus_addr[31:24] == 8'hD0) |-> denied);

   // R11
   wr_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> (bus_wr && !denied));
endmodule

bind mmio_gatekeeper gatekeeper_chk #(.N_CORES(N_CORES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_mmio_gatekeeper.sv
`timescale 1ns/1ps
module sim_mmio_gatekeeper;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  bus_addr = '0;
   logic         bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  rom_rdata = 32'h0A0A_0001;
   logic [31:0]  ram_rdata = 32'h0B0B_0002;
   logic [223:0] core_rdata;
   logic         sel_rom, sel_ram, out_rd, out_wr, denied, app_mode;
   logic [6:0]   sel_core;
   logic [31:0]  out_wdata, rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   for (genvar c = 0; c < 7; c++) begin : g_src
      assign core_rdata[c*32 +: 32] = 32'hC0DE_0000 + 32'(c);
   end

   mmio_gatekeeper u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rom_rdata(rom_rdata),
      .ram_rdata(ram_rdata), .core_rdata(core_rdata), .sel_rom(sel_rom),
      .sel_ram(sel_ram), .sel_core(sel_core), .out_rd(out_rd), .out_wr(out_wr),
      .out_wdata(out_wdata), .rdata(rdata), .denied(denied), .app_mode(app_mode)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] core_val(input int c);
      return 32'hC0DE_0000 + 32'(c);
   endfunction

   task automatic drive(input logic [31:0] a, input logic rd, input logic wr,
                        input logic [31:0] wd);
      @(negedge clk);
      bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
      #1;
   endtask

   task automatic idle();
      drive(32'h0, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic expect_read_core(input string req, input logic [31:0] a, input int c);
      drive(a, 1'b1, 1'b0, 32'h0);
      chk({req, " sel_core"}, 32'(sel_core), 32'(1) << c);
      chk({req, " rdata"}, rdata, core_val(c));
      chk({req, " denied"}, 32'(denied), 0);
   endtask

   task automatic expect_refused(input string req, input logic [31:0] a,
                                 input logic rd, input logic wr);
      drive(a, rd, wr, 32'hDEAD_BEEF);
      chk({req, " denied"}, 32'(denied), 1);
      chk({req, " selects"}, {23'h0, sel_rom, sel_ram, sel_core}, 0);
      chk({req, " rdata"}, rdata, 0);
      chk({req, " out_wr/out_rd"}, {out_wr, out_rd}, 0);
      chk({req, " out_wdata"}, out_wdata, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      idle();
      chk("R6 reset mode", 32'(app_mode), 0);
      chk("R4 idle rdata", rdata, 0);
      chk("R3 idle denied", 32'(denied), 0);
   endtask

   task automatic t_memories();
      drive(32'h0000_17FC, 1, 0, 0);
      chk("R1 rom top sel", 32'(sel_rom), 1);
      chk("R4 rom data", rdata, 32'h0A0A_0001);
      drive(32'h0000_0000, 1, 0, 0);
      chk("R1 rom base sel", 32'(sel_rom), 1);
      drive(32'h4001_FFFC, 1, 0, 0);
      chk("R1 ram top sel", 32'(sel_ram), 1);
      chk("R4 ram data", rdata, 32'h0B0B_0002);
      expect_refused("R1 rom beyond", 32'h0000_1800, 1, 0);
      expect_refused("R1 ram beyond", 32'h4002_0000, 1, 0);
   endtask

   task automatic t_cores();
      expect_read_core("R2 entropy", 32'hC000_0010, 0);
      expect_read_core("R2 timer",   32'hC100_0000, 1);
      expect_read_core("R2 uart",    32'hC300_0004, 3);
      expect_read_core("R2 touch",   32'hC400_0000, 4);
      expect_read_core("R2 fwram",   32'hD000_07FC, 5);
      expect_read_core("R2 sysctl",  32'hFF00_0000, 6);
      expect_read_core("R8 devid fw", 32'hFF00_0200, 6);
      expect_read_core("R8 seed fw",  32'hFF00_0304, 6);
   endtask

   task automatic t_reserved();
      expect_refused("R3 reserved read", 32'h8000_0000, 1, 0);
      expect_refused("R3 reserved write", 32'hA000_0040, 0, 1);
      expect_refused("R3 unassigned C5", 32'hC500_0000, 1, 0);
      expect_refused("R3 unassigned E0", 32'hE000_0000, 0, 1);
   endtask

   task automatic t_forward();
      drive(32'hC300_0008, 0, 1, 32'h1234_5678);
      chk("R11 granted out_wr", 32'(out_wr), 1);
      chk("R11 granted wdata", out_wdata, 32'h1234_5678);
      chk("R11 no out_rd on write", 32'(out_rd), 0);
      drive(32'h4000_0100, 1, 0, 32'h5555_AAAA);
      chk("R11 read out_rd", 32'(out_rd), 1);
      chk("R11 read wdata zero", out_wdata, 0);
   endtask

   task automatic t_key_once();
      expect_read_core("R9 key word2 first", 32'hC200_0008, 2);
      idle();
      expect_refused("R9 key word2 again", 32'hC200_0008, 1, 0);
      expect_read_core("R9 key word3 untouched", 32'hC200_000C, 2);
      // back-to-back reads of one word
      expect_read_core("R9 key word5 cycle1", 32'hC200_0014, 2);
      expect_refused("R9 key word5 cycle2", 32'hC200_0014, 1, 0);
      expect_refused("R10 key write", 32'hC200_0000, 0, 1);
      expect_refused("R10 key past end", 32'hC200_0020, 1, 0);
      expect_read_core("R10 key word0 after write", 32'hC200_0000, 2);
   endtask

   task automatic t_switch();
      drive(32'hFF00_0100, 1, 0, 0);
      chk("R5 mode read fw", rdata, 32'h0);
      chk("R5 mode read no sel", 32'(sel_core), 0);
      chk("R5 mode read denied", 32'(denied), 0);
      drive(32'hFF00_0100, 0, 1, 32'h0000_0000);
      chk("R5 write cycle still fw", 32'(app_mode), 0);
      chk("R5 mode write denied", 32'(denied), 0);
      expect_refused("R7 fwram right after switch", 32'hD000_0000, 1, 0);
      chk("R5 app after write", 32'(app_mode), 1);
   endtask

   task automatic t_app();
      drive(32'hFF00_0100, 1, 0, 0);
      chk("R5 mode read app", rdata, 32'hFFFF_FFFF);
      expect_refused("R7 fwram write", 32'hD000_0010, 0, 1);
      expect_refused("R7 key unread word", 32'hC200_001C, 1, 0);
      expect_refused("R8 devid hi", 32'hFF00_0204, 1, 0);
      expect_refused("R8 seed a", 32'hFF00_0300, 0, 1);
      expect_read_core("R8 sysctl other", 32'hFF00_0000, 6);
      expect_read_core("R2 entropy in app", 32'hC000_0000, 0);
      expect_refused("R6 mode write in app", 32'hFF00_0100, 0, 1);
      idle();
      chk("R6 still app", 32'(app_mode), 1);
   endtask

   task automatic t_after_reset();
      do_reset();
      idle();
      chk("R6 fw after reset", 32'(app_mode), 0);
      expect_read_core("R12 key word2 again", 32'hC200_0008, 2);
      expect_read_core("R12 key word5 again", 32'hC200_0014, 2);
   endtask

   initial begin
      t_reset();
      t_memories();
      t_cores();
      t_reserved();
      t_forward();
      t_key_once();
      t_switch();
      t_app();
      t_after_reset();
      idle();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule